// File: doc/BRIEF.md
# RGB565 Framebuffer Scanout with Blanking

This block streams a 16-bit-per-pixel framebuffer to a panel as 24-bit RGB. At the start of every frame it latches the configured width, height and base word address. It then walks the frame in raster order, issuing one read per pixel to an external synchronous memory port with consecutive word addresses. Each returned RGB565 word is widened to 8 bits per channel by repeating the top bits of each field. The pixels leave on a valid/ready stream that marks the first pixel of the frame and the last pixel of every line.

A display-enable input selects between memory pixels and a black frame. The block samples it only when a frame starts, so a frame is never partly blanked. A blanked frame issues no memory reads. The block leaves reset in the blanked state. Whenever the blank state or the latched geometry differs from that of the previous frame, the first pixel of the new frame carries a full-refresh flag. A zero width or height holds the block idle. The default geometry limit is a 480 by 640 portrait panel. The actual geometry comes from the configuration inputs, so a small frame can be used.

Top module: `sf_scanout`

## Requirements
- R1: Each frame holds cfg_height lines of cfg_width pixels. o_sof is high only on the first pixel of the frame and o_eol only on the last pixel of each line. Geometry and base are latched when the frame starts, and frames follow each other with no configuration step in between.
- R2: Pixel i of a displayed frame (counting in raster order from 0) is the word read from address cfg_base + i. Exactly one memory read is issued per displayed pixel, and the read data is taken on the cycle after mem_rd_en.
- R3: A source word carries red in bits [15:11], green in [10:5] and blue in [4:0]. The output o_rgb is {R8, G8, B8} with red in [23:16], green in [15:8] and blue in [7:0]. R8 = {r, r[4:2]}, G8 = {g, g[5:4]} and B8 = {b, b[4:2]}.
- R4: If disp_on is low when a frame starts, every pixel of that frame is zero and the frame issues no memory read.
- R5: After reset, o_valid and mem_rd_en stay low while the geometry is zero. The stored blank state starts as blanked, and the first frame after reset carries the full-refresh flag.
- R6: disp_on is sampled only at frame start. A change during a frame first takes effect on the next frame.
- R7: While cfg_width or cfg_height is zero, no frame starts: no pixel is produced and no memory read is issued.
- R8: While o_valid is high and o_ready is low, o_valid, o_rgb, o_sof, o_eol and o_full hold their values.
- R9: o_full is high on the first pixel of a frame whose blank state, width or height differs from the previous frame, and low on all other pixels.
- R10: Under any o_ready pattern, the pixel sequence is the same as with o_ready held high, with no pixel lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | XW | Pixels per line (0 = off) |
| cfg_height | input | YW | Lines per frame (0 = off) |
| cfg_base | input | AW | Word address of the first pixel |
| disp_on | input | 1 | High shows memory pixels, low blanks |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | 16 | Read data, valid the cycle after the strobe |
| o_valid | output | 1 | Output pixel valid |
| o_ready | input | 1 | Sink accepts the pixel |
| o_rgb | output | 24 | Pixel {R8,G8,B8} |
| o_sof | output | 1 | First pixel of the frame |
| o_eol | output | 1 | Last pixel of a line |
| o_full | output | 1 | Full-refresh flag on the first pixel |

## Verification
The bench checks that each frame restarts at the base address. A design that keeps counting across frames would show the wrong data in the second frame. It drops disp_on in the middle of a frame and expects that frame to finish from memory and the next one to be black. Any leak of the new blank state into the running frame shows up as zero pixels or as a wrong read count. Random backpressure checks that a full buffer neither drops nor repeats pixels. The bench also checks the full-refresh flag: it must appear only on the first frame after a change of blank state or geometry, and frames with zero width or height must produce no pixel and no read.

// File: rtl/sf_pkg.sv
package sf_pkg;

  typedef struct packed {
    logic        sof;
    logic        eol;
    logic        full;
    logic [23:0] rgb;
  } sf_pix_t;

  // Widen one RGB565 word to 8 bits per channel by top-bit repetition.
  function automatic logic [23:0] sf_expand565(input logic [15:0] w);
    logic [4:0] r;
    logic [5:0] g;
    logic [4:0] b;
    r = w[15:11];
    g = w[10:5];
    b = w[4:0];
    return {r, r[4:2], g, g[5:4], b, b[4:2]};
  endfunction

  // A frame needs a full refresh when its blank state or geometry moved.
  function automatic logic sf_need_full(input logic blank_now,
                                        input logic blank_prev,
                                        input logic geo_moved);
    return (blank_now != blank_prev) || geo_moved;
  endfunction

endpackage

// File: rtl/sf_timing.sv
module sf_timing #(
  parameter int XW = 9,
  parameter int YW = 10,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] cfg_width,
  input  logic [YW-1:0] cfg_height,
  input  logic [AW-1:0] cfg_base,
  input  logic          disp_on,
  input  logic          go,
  output logic          slot_valid,
  output logic          slot_sof,
  output logic          slot_eol,
  output logic          slot_blank,
  output logic          slot_full,
  output logic [AW-1:0] slot_addr,
  output logic          idle
);
  import sf_pkg::*;

  logic          run_q;
  logic [XW-1:0] x_q, w_q, pw_q;
  logic [YW-1:0] y_q, h_q, ph_q;
  logic [AW-1:0] addr_q;
  logic          blank_q, pblank_q, full_q;

  logic geo_ok, last_x, last_y, geo_moved;

  assign geo_ok    = (cfg_width != '0) && (cfg_height != '0);
  assign last_x    = (x_q == w_q - 1'b1);
  assign last_y    = (y_q == h_q - 1'b1);
  assign geo_moved = (cfg_width != pw_q) || (cfg_height != ph_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      x_q      <= '0;
      y_q      <= '0;
      w_q      <= '0;
      h_q      <= '0;
      pw_q     <= '0;
      ph_q     <= '0;
      addr_q   <= '0;
      blank_q  <= 1'b1;
      pblank_q <= 1'b1;
      full_q   <= 1'b0;
    end else if (!run_q) begin
      if (geo_ok) begin
        run_q    <= 1'b1;
        w_q      <= cfg_width;
        h_q      <= cfg_height;
        pw_q     <= cfg_width;
        ph_q     <= cfg_height;
        blank_q  <= !disp_on;
        pblank_q <= !disp_on;
        full_q   <= sf_need_full(!disp_on, pblank_q, geo_moved);
        x_q      <= '0;
        y_q      <= '0;
        addr_q   <= cfg_base;
      end
    end else if (go) begin
      if (last_x) begin
        x_q <= '0;
        if (last_y) run_q <= 1'b0;
        else        y_q   <= y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
      if (!blank_q) addr_q <= addr_q + 1'b1;
    end
  end

  assign slot_valid = run_q;
  assign slot_sof   = (x_q == '0) && (y_q == '0);
  assign slot_eol   = last_x;
  assign slot_blank = blank_q;
  assign slot_full  = full_q && slot_sof;
  assign slot_addr  = addr_q;
  assign idle       = !run_q;

endmodule

// File: rtl/sf_fifo.sv
module sf_fifo #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 27,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp_q] <= din;
  end

  assign dout  = store[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/sf_scanout.sv
module sf_scanout #(
  parameter int MAX_W = 480,
  parameter int MAX_H = 640,
  parameter int AW    = 20,
  parameter int DEPTH = 2,
  localparam int XW = $clog2(MAX_W + 1),
  localparam int YW = $clog2(MAX_H + 1),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] cfg_width,
  input  logic [YW-1:0] cfg_height,
  input  logic [AW-1:0] cfg_base,
  input  logic          disp_on,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [23:0]   o_rgb,
  output logic          o_sof,
  output logic          o_eol,
  output logic          o_full
);
  import sf_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic          slot_valid, slot_sof, slot_eol, slot_full;
  logic          frame_blank, tm_idle, slot_go, credit, push, pop;
  logic [CW-1:0] fifo_cnt, res_q;

  sf_timing #(.XW(XW), .YW(YW), .AW(AW)) u_timing (
    .clk(clk), .rst_n(rst_n),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_base(cfg_base),
    .disp_on(disp_on), .go(slot_go),
    .slot_valid(slot_valid), .slot_sof(slot_sof), .slot_eol(slot_eol),
    .slot_blank(frame_blank), .slot_full(slot_full), .slot_addr(mem_addr),
    .idle(tm_idle)
  );

  // Credit: a slot is issued only if the buffer has room for it, counting
  // both the stored pixels and the one still in the memory pipeline.
  assign pop       = o_valid && o_ready;
  assign credit    = (res_q < CW'(DEPTH)) || pop;
  assign slot_go   = slot_valid && credit;
  assign mem_rd_en = slot_go && !frame_blank;

  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_q + CW'(slot_go) - CW'(pop);
  end

  // One stage matching the memory read latency.
  logic d_valid, d_blank, d_sof, d_eol, d_full;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_blank <= 1'b1;
      d_sof   <= 1'b0;
      d_eol   <= 1'b0;
      d_full  <= 1'b0;
    end else begin
      d_valid <= slot_go;
      d_blank <= frame_blank;
      d_sof   <= slot_sof;
      d_eol   <= slot_eol;
      d_full  <= slot_full;
    end
  end

  sf_pix_t in_pix, out_pix;
  assign push        = d_valid;
  assign in_pix.sof  = d_sof;
  assign in_pix.eol  = d_eol;
  assign in_pix.full = d_full;
  assign in_pix.rgb  = d_blank ? 24'h0 : sf_expand565(mem_rdata);

  sf_fifo #(.DEPTH(DEPTH), .WIDTH($bits(sf_pix_t))) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .din(in_pix), .pop(pop),
    .dout(out_pix), .count(fifo_cnt)
  );

  assign o_valid = (fifo_cnt != '0);
  assign o_rgb   = out_pix.rgb;
  assign o_sof   = out_pix.sof;
  assign o_eol   = out_pix.eol;
  assign o_full  = out_pix.full;

endmodule

// File: rtl/sf_scanout_chk.sv
module sf_scanout_chk #(
  parameter int XW    = 9,
  parameter int YW    = 10,
  parameter int CW    = 2,
  parameter int DEPTH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          o_valid,
  input logic          o_ready,
  input logic [23:0]   o_rgb,
  input logic          o_sof,
  input logic          o_eol,
  input logic          o_full,
  input logic          mem_rd_en,
  input logic          frame_blank,
  input logic [CW-1:0] fifo_cnt,
  input logic          slot_go,
  input logic          tm_idle,
  input logic [XW-1:0] cfg_width,
  input logic [YW-1:0] cfg_height,
  input logic          push,
  input logic          pop
);
  // R8: a stalled pixel holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_rgb) && $stable(o_sof)
                            && $stable(o_eol) && $stable(o_full));

  // R4: a blanked frame never touches memory
  a_r4_no_read_blank: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !frame_blank);

  // R7: zero geometry keeps the block idle
  a_r7_zero_geom: assert property (@(posedge clk) disable iff (!rst_n)
    tm_idle && (cfg_width == '0 || cfg_height == '0) |=> !slot_go);

  // R10: the buffer never overflows
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R10: no push into a full buffer unless a pixel leaves
  a_r10_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fifo_cnt < CW'(DEPTH)) || pop);

  // R9: the refresh flag only rides on the first pixel
  a_r9_full_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_full |-> o_sof);
endmodule

bind sf_scanout sf_scanout_chk #(.XW(XW), .YW(YW), .CW(CW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sf_scanout_bench.sv
module sf_scanout_bench;
  localparam int AW = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  cfg_width = '0;
  logic [9:0]  cfg_height = '0;
  logic [AW-1:0] cfg_base = '0;
  logic        disp_on = 1'b0;
  logic        mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        o_valid, o_sof, o_eol, o_full;
  logic        o_ready = 1'b0;
  logic [23:0] o_rgb;

  int total = 0, bad = 0;
  int log_n = 0, reads = 0, quiet = 0;
  bit bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [23:0] lg_rgb [512];
  bit lg_sof [512], lg_eol [512], lg_full [512];

  always #4 clk = ~clk;

  sf_scanout u_sf_scanout (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_base(cfg_base), .disp_on(disp_on), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .o_valid(o_valid),
    .o_ready(o_ready), .o_rgb(o_rgb), .o_sof(o_sof), .o_eol(o_eol),
    .o_full(o_full)
  );

  function automatic logic [15:0] pat(input logic [AW-1:0] a);
    logic [15:0] p;
    p = a[15:0] * 16'h9E37;
    return p + 16'h1234;
  endfunction

  // Independent restatement of the channel widening.
  function automatic logic [23:0] exp_px(input logic [AW-1:0] a);
    logic [15:0] p;
    logic [7:0] r, g, b;
    p = pat(a);
    r = ({3'b0, p[15:11]} << 3) | ({3'b0, p[15:11]} >> 2);
    g = ({2'b0, p[10:5]} << 2) | ({2'b0, p[10:5]} >> 4);
    b = ({3'b0, p[4:0]} << 3) | ({3'b0, p[4:0]} >> 2);
    return {r, g, b};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(mem_addr);

  always @(negedge clk) begin
    if (bp_mode) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      o_ready = lfsr[0] & (lfsr[3] | lfsr[5]);
    end else begin
      o_ready = 1'b1;
    end
    if (o_valid && o_ready) begin
      if (log_n < 512) begin
        lg_rgb[log_n]  = o_rgb;
        lg_sof[log_n]  = o_sof;
        lg_eol[log_n]  = o_eol;
        lg_full[log_n] = o_full;
      end
      log_n++;
    end
    if (mem_rd_en) reads++;
    if (o_valid) quiet = 0; else quiet++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  task automatic drain();
    @(posedge clk); #2;
    cfg_width = '0;
    do @(posedge clk); while (quiet < 12);
  endtask

  task automatic collect(input int w, input int h, input int base,
                         input bit disp, input int nfr);
    @(posedge clk); #2;
    log_n = 0;
    reads = 0;
    cfg_base = AW'(base);
    disp_on = disp;
    cfg_height = 10'(h);
    cfg_width = 9'(w);
    while (log_n < nfr * w * h) @(posedge clk);
    drain();
  endtask

  task automatic verify(input int nfr, input int w, input int h, input int base,
                        input bit blank, input bit first_full, input string req);
    for (int f = 0; f < nfr; f++) begin
      int ed = 0, em = 0, fd = 0;
      logic [23:0] a_px = '0, e_px = '0;
      for (int i = 0; i < w * h; i++) begin
        int k = f * w * h + i;
        logic [23:0] e;
        bit ef;
        e = blank ? 24'h0 : exp_px(AW'(base + i));
        ef = (i == 0) && (f == 0) && first_full;
        if (lg_rgb[k] !== e) begin
          if (ed == 0) begin a_px = lg_rgb[k]; e_px = e; end
          ed++;
        end
        if (lg_sof[k] != (i == 0) || lg_eol[k] != ((i % w) == w - 1)) em++;
        if (lg_full[k] != ef) fd++;
      end
      check(ed == 0, req, $sformatf("frame %0d pixel data", f), int'(a_px), int'(e_px));
      check(em == 0, "R1", $sformatf("frame %0d sof/eol markers", f), em, 0);
      check(fd == 0, "R9", $sformatf("frame %0d full flag", f), fd, 0);
    end
  endtask

  task automatic t_reset();
    check(o_valid == 1'b0, "R5", "o_valid after reset", o_valid, 0);
    check(mem_rd_en == 1'b0, "R5", "mem_rd_en after reset", mem_rd_en, 0);
    check(log_n == 0, "R5", "pixels after reset", log_n, 0);
  endtask

  task automatic t_basic();
    collect(4, 3, 'h100, 1'b1, 2);
    check(log_n >= 24, "R1", "pixel count", log_n, 24);
    verify(2, 4, 3, 'h100, 1'b0, 1'b1, "R2 R3 R5");
  endtask

  task automatic t_backpressure();
    bp_mode = 1'b1;
    collect(4, 3, 'h100, 1'b1, 2);
    bp_mode = 1'b0;
    verify(2, 4, 3, 'h100, 1'b0, 1'b0, "R8 R10");
  endtask

  task automatic t_blank();
    collect(4, 3, 'h40, 1'b0, 2);
    verify(2, 4, 3, 'h40, 1'b1, 1'b1, "R4");
    check(reads == 0, "R4", "reads in blanked frames", reads, 0);
    collect(4, 3, 'h40, 1'b1, 1);
    verify(1, 4, 3, 'h40, 1'b0, 1'b1, "R9 unblank");
  endtask

  task automatic t_geom();
    collect(5, 2, 'h200, 1'b1, 2);
    verify(2, 5, 2, 'h200, 1'b0, 1'b1, "R1 R9 geometry");
  endtask

  task automatic t_zero();
    @(posedge clk); #2;
    log_n = 0; reads = 0; disp_on = 1'b1;
    cfg_width = '0; cfg_height = 10'd3;
    repeat (60) @(posedge clk);
    check(log_n == 0 && reads == 0, "R7", "zero width activity", log_n + reads, 0);
    #2;
    cfg_width = 9'd3; cfg_height = '0;
    repeat (60) @(posedge clk);
    check(log_n == 0 && reads == 0, "R7", "zero height activity", log_n + reads, 0);
    #2;
    cfg_width = '0;
  endtask

  task automatic t_midframe();
    @(posedge clk); #2;
    log_n = 0; reads = 0;
    cfg_base = '0; disp_on = 1'b1;
    cfg_height = 10'd4; cfg_width = 9'd8;
    while (log_n < 5) @(posedge clk);
    #2;
    disp_on = 1'b0;
    while (log_n < 64) @(posedge clk);
    drain();
    verify(1, 8, 4, 0, 1'b0, 1'b1, "R6 running frame");
    for (int i = 0; i < 32; i++) begin
      lg_rgb[i] = lg_rgb[32 + i]; lg_sof[i] = lg_sof[32 + i];
      lg_eol[i] = lg_eol[32 + i]; lg_full[i] = lg_full[32 + i];
    end
    verify(1, 8, 4, 0, 1'b1, 1'b1, "R6 next frame");
    check(reads == 32, "R6", "reads across change", reads, 32);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_blank();
    t_geom();
    t_zero();
    t_midframe();
    summary();
    $finish;
  end

endmodule